// File: doc/BRIEF.md
# Iterative Radix-2 Walsh–Hadamard Transform Engine

This block computes an unscaled 32-point Walsh–Hadamard transform with one sum/difference butterfly shared over time. Samples stream in one per cycle through a load port. A start pulse launches the computation. After a fixed number of cycles a done pulse appears, and the coefficients can then be pulled out one at a time through an unload port, in natural (Hadamard) order.

Every stage uses the same access pattern. Words `i` and `i + N/2` are read from one buffer, and their sum and difference are written to slots `2i` and `2i + 1` of the other buffer. Two buffers alternate roles from stage to stage. After `log2(N)` stages the data is already in natural order, so no reorder pass and no per-stage address arithmetic are needed. Data words carry `LOG2N` guard bits from the moment they are loaded, so no stage can overflow.

Top module: `wht_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `unload_valid` are low.
- R2: Each cycle with `load_valid` high and `busy` low stores `load_data` (two's complement) at the next sample index, starting at index 0. The index wraps to 0 after N samples, so extra samples overwrite from index 0. An accepted `start` returns the index to 0.
- R3: `start` sampled high while `busy` is low sets `busy` high from the next cycle. `busy` stays high until the transform completes. A `start` while `busy` is high has no effect.
- R4: A transform occupies exactly `LOG2N * N/2` = 80 busy cycles. In the cycle after the last one, `busy` is low and `done` is high, for that single cycle only.
- R5: Coefficient k equals the sum over i of x[i], negated when the number of ones in (i AND k) is odd. There is no scaling, and the result is given at `OUT_W = IN_W + LOG2N` bits signed.
- R6: Each cycle with `unload_req` high and `busy` low returns the next coefficient on `unload_data`, with `unload_valid` high one cycle later. Order is k = 0, 1, 2, … and wraps after N. An accepted `start` returns this index to 0.
- R7: Full-scale inputs (all most-negative or all most-positive) produce the exact extreme coefficient without wrap-around.
- R8: While `busy` is high, `load_valid` and `unload_req` are ignored. No sample is stored, and `unload_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_valid | input | 1 | Sample strobe |
| load_data | input | IN_W | Signed input sample |
| start | input | 1 | Launch transform |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| unload_req | input | 1 | Request next coefficient |
| unload_valid | output | 1 | Coefficient valid, one cycle after request |
| unload_data | output | OUT_W | Signed coefficient |

## Verification
The hardest situation to create from the ports is traffic arriving while the engine is mid-transform: loads, unload requests and repeated start pulses that must all be dropped without disturbing the stage data or the cycle count. One scenario drives all three on every busy cycle. It then confirms that the busy span is still 80 cycles, that no coefficient is returned, and that all 32 coefficients still match the originally loaded vector. Separate scenarios cover load-index wrap, unload-index wrap, and full-scale inputs that reach the guard-bit limit.

// File: rtl/wht_pkg.sv
package wht_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/wht_butterfly.sv
// Radix-2 processing element: one sum and one difference per cycle.
module wht_butterfly #(
  parameter int W = 17
) (
  input  logic [W-1:0] op_lo,
  input  logic [W-1:0] op_hi,
  output logic [W-1:0] res_sum,
  output logic [W-1:0] res_dif
);

  always_comb begin
    res_sum = op_lo + op_hi;
    res_dif = op_lo - op_hi;
  end

endmodule

// File: rtl/wht_seq.sv
// Stage / pair sequencer: walks LOG2N stages of N/2 butterflies each.
module wht_seq
  import wht_pkg::*;
#(
  parameter int LOG2N = 5,
  parameter int PW    = LOG2N - 1,
  parameter int SW    = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] stage,
  output logic [PW-1:0] pair
);

  localparam int HALF = 1 << PW;

  seq_state_e    state_q, state_d;
  logic [SW-1:0] stage_q, stage_d;
  logic [PW-1:0] pair_q,  pair_d;
  logic          done_q,  done_d;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    pair_d  = pair_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          stage_d = '0;
          pair_d  = '0;
        end
      end
      ST_RUN: begin
        pair_d = pair_q + 1'b1;
        if (pair_q == PW'(HALF - 1)) begin
          pair_d = '0;
          if (stage_q == SW'(LOG2N - 1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            stage_d = stage_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      pair_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      pair_q  <= pair_d;
      done_q  <= done_d;
    end
  end

  assign busy  = (state_q == ST_RUN);
  assign done  = done_q;
  assign stage = stage_q;
  assign pair  = pair_q;

endmodule

// File: rtl/wht_bank.sv
// One ping-pong buffer: a sample write port, a paired (2i, 2i+1) write port
// and two combinational read ports.
module wht_bank #(
  parameter int DEPTH = 32,
  parameter int W     = 17,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  input  logic          pw_en,
  input  logic [AW-2:0] pw_idx,
  input  logic [W-1:0]  pw_even,
  input  logic [W-1:0]  pw_odd,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data
);

  logic [W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam bit IS_ODD = (g % 2) == 1;
    logic         we;
    logic [W-1:0] wd;
    logic [W-1:0] word_q;

    always_comb begin
      we = 1'b0;
      wd = ld_data;
      if (pw_en && (pw_idx == (AW-1)'(g / 2))) begin
        we = 1'b1;
        wd = IS_ODD ? pw_odd : pw_even;
      end else if (ld_en && (ld_addr == AW'(g))) begin
        we = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we) word_q <= wd;
    end

    assign words[g] = word_q;
  end

  assign ra_data = words[ra_addr];
  assign rb_data = words[rb_addr];

endmodule

// File: rtl/wht_engine.sv
module wht_engine
  import wht_pkg::*;
#(
  parameter int LOG2N = 5,
  parameter int IN_W  = 12,
  parameter int OUT_W = IN_W + LOG2N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [IN_W-1:0]  load_data,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             unload_req,
  output logic             unload_valid,
  output logic [OUT_W-1:0] unload_data
);

  localparam int N          = 1 << LOG2N;
  localparam int AW         = LOG2N;
  localparam int PW         = LOG2N - 1;
  localparam int SW         = (LOG2N > 1) ? $clog2(LOG2N) : 1;
  localparam int GUARD      = OUT_W - IN_W;
  localparam bit FINAL_IN_B = (LOG2N % 2) == 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // sequencer
  logic          busy_w;
  logic [SW-1:0] stage_w;
  logic [PW-1:0] pair_w;

  wht_seq #(.LOG2N(LOG2N), .PW(PW), .SW(SW)) u_seq (
    .clk   (clk),
    .rst_ni(rst_ni),
    .start (start),
    .busy  (busy_w),
    .done  (done),
    .stage (stage_w),
    .pair  (pair_w)
  );
  assign busy = busy_w;

  // port acceptance
  logic start_acc, ld_fire, ul_fire;
  assign start_acc = start & ~busy_w;
  assign ld_fire   = load_valid & ~busy_w;
  assign ul_fire   = unload_req & ~busy_w;

  // load / unload index counters
  logic [AW-1:0]    ld_idx_q, ld_idx_d;
  logic [AW-1:0]    ul_idx_q, ul_idx_d;
  logic             ul_vld_q, ul_vld_d;
  logic [OUT_W-1:0] ul_dat_q, ul_dat_d;
  logic [OUT_W-1:0] final_rd;

  always_comb begin
    ld_idx_d = ld_idx_q;
    ul_idx_d = ul_idx_q;
    if (ld_fire) ld_idx_d = ld_idx_q + 1'b1;
    if (ul_fire) ul_idx_d = ul_idx_q + 1'b1;
    if (start_acc) begin
      ld_idx_d = '0;
      ul_idx_d = '0;
    end
    ul_vld_d = ul_fire;
    ul_dat_d = ul_fire ? final_rd : ul_dat_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_idx_q <= '0;
      ul_idx_q <= '0;
      ul_vld_q <= 1'b0;
      ul_dat_q <= '0;
    end else begin
      ld_idx_q <= ld_idx_d;
      ul_idx_q <= ul_idx_d;
      ul_vld_q <= ul_vld_d;
      ul_dat_q <= ul_dat_d;
    end
  end

  assign unload_valid = ul_vld_q;
  assign unload_data  = ul_dat_q;

  // datapath: fixed geometry, read i and i+N/2, write 2i and 2i+1
  logic             src_is_b;
  logic [AW-1:0]    rd_lo_addr, rd_hi_addr;
  logic [OUT_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [OUT_W-1:0] op_lo, op_hi, res_sum, res_dif;
  logic [OUT_W-1:0] ld_ext;

  assign src_is_b   = stage_w[0];
  assign rd_lo_addr = busy_w ? {1'b0, pair_w} : ul_idx_q;
  assign rd_hi_addr = {1'b1, pair_w};
  assign ld_ext     = {{GUARD{load_data[IN_W-1]}}, load_data};

  wht_bank #(.DEPTH(N), .W(OUT_W), .AW(AW)) u_bank_a (
    .clk    (clk),
    .ld_en  (ld_fire),
    .ld_addr(ld_idx_q),
    .ld_data(ld_ext),
    .pw_en  (busy_w & src_is_b),
    .pw_idx (pair_w),
    .pw_even(res_sum),
    .pw_odd (res_dif),
    .ra_addr(rd_lo_addr),
    .rb_addr(rd_hi_addr),
    .ra_data(a_lo),
    .rb_data(a_hi)
  );

  wht_bank #(.DEPTH(N), .W(OUT_W), .AW(AW)) u_bank_b (
    .clk    (clk),
    .ld_en  (1'b0),
    .ld_addr('0),
    .ld_data('0),
    .pw_en  (busy_w & ~src_is_b),
    .pw_idx (pair_w),
    .pw_even(res_sum),
    .pw_odd (res_dif),
    .ra_addr(rd_lo_addr),
    .rb_addr(rd_hi_addr),
    .ra_data(b_lo),
    .rb_data(b_hi)
  );

  assign op_lo = src_is_b ? b_lo : a_lo;
  assign op_hi = src_is_b ? b_hi : a_hi;

  wht_butterfly #(.W(OUT_W)) u_pe (
    .op_lo  (op_lo),
    .op_hi  (op_hi),
    .res_sum(res_sum),
    .res_dif(res_dif)
  );

  if (FINAL_IN_B) begin : g_final_b
    assign final_rd = b_lo;
  end else begin : g_final_a
    assign final_rd = a_lo;
  end

endmodule

// File: rtl/wht_engine_chk.sv
module wht_engine_chk #(
  parameter int LOG2N = 5
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic unload_req,
  input logic unload_valid
);

  localparam int RUN_CYC = LOG2N * (1 << (LOG2N - 1));
  localparam int CW      = $clog2(RUN_CYC + 2);

  logic [CW-1:0] run_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt_q <= '0;
    else if (busy) run_cnt_q <= run_cnt_q + 1'b1;
    else           run_cnt_q <= '0;
  end

  // R1
  p_quiet_in_reset_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done && !unload_valid);
  // R3
  p_busy_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  p_busy_until_done_r3:  assert property (@(posedge clk) disable iff (!rst_n) busy |=> busy || done);
  // R4
  p_done_single_r4:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r4:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_run_length_r4:   assert property (@(posedge clk) disable iff (!rst_n) done |-> run_cnt_q == CW'(RUN_CYC));
  // R6, R8
  p_unload_idle_r8:  assert property (@(posedge clk) disable iff (!rst_n) unload_valid |-> $past(unload_req && !busy));

endmodule

bind wht_engine wht_engine_chk #(.LOG2N(LOG2N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .unload_req  (unload_req),
  .unload_valid(unload_valid)
);

// File: tb/wht_engine_tb_top.sv
module wht_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LOG2N      = 5;
  localparam int IN_W       = 12;
  localparam int OUT_W      = IN_W + LOG2N;
  localparam int N          = 1 << LOG2N;
  localparam int RUN_CYC    = LOG2N * N / 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load_valid;
  logic [IN_W-1:0]  load_data;
  logic             start;
  logic             busy;
  logic             done;
  logic             unload_req;
  logic             unload_valid;
  logic [OUT_W-1:0] unload_data;

  int     n_checks = 0;
  int     n_fails  = 0;
  bit     finished = 1'b0;
  int     xin  [N];
  longint yexp [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  wht_engine #(.LOG2N(LOG2N), .IN_W(IN_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_valid  (load_valid),
    .load_data   (load_data),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .unload_req  (unload_req),
    .unload_valid(unload_valid),
    .unload_data (unload_data)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference transform from the requirement formula (R5)
  task automatic compute_ref();
    for (int k = 0; k < N; k++) begin
      longint s = 0;
      for (int i = 0; i < N; i++) begin
        if ($countones(i & k) % 2 == 1) s -= xin[i];
        else                            s += xin[i];
      end
      yexp[k] = s;
    end
  endtask

  task automatic load_vec(input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      load_valid = 1'b1;
      load_data  = IN_W'(xin[i % N]);
    end
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  // start a run, optionally disturbing every busy cycle; checks R3, R4, R8
  task automatic run_xform(input bit disturb);
    int cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3", "busy after start", longint'(busy), 1);
    while (busy && cnt < 4 * RUN_CYC) begin
      cnt++;
      chk("R4", "done low while busy", longint'(done), 0);
      if (disturb) begin
        chk("R8", "no unload while busy", longint'(unload_valid), 0);
        load_valid = 1'b1;
        load_data  = IN_W'(cnt * 37);
        start      = 1'b1;
        unload_req = 1'b1;
      end
      @(negedge clk);
      load_valid = 1'b0;
      start      = 1'b0;
      unload_req = 1'b0;
    end
    chk("R4", "busy cycle count", cnt, RUN_CYC);
    chk("R4", "done pulse", longint'(done), 1);
    chk("R8", "no unload at done", longint'(unload_valid), 0);
    @(negedge clk);
    chk("R4", "done falls", longint'(done), 0);
  endtask

  task automatic unload_all(input string req, input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      unload_req = 1'b1;
      @(negedge clk);
      unload_req = 1'b0;
      chk("R6", "unload_valid", longint'(unload_valid), 1);
      chk(req, $sformatf("coef %0d", k % N), longint'($signed(unload_data)), yexp[k % N]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", longint'(busy), 0);
    chk("R1", "done in reset", longint'(done), 0);
    chk("R1", "valid in reset", longint'(unload_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after reset", longint'(busy), 0);
    chk("R1", "valid after reset", longint'(unload_valid), 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < N; i++) xin[i] = i;
    compute_ref();
    load_vec(N);
    run_xform(1'b0);
    unload_all("R5", N);
  endtask

  task automatic t_impulse();
    for (int i = 0; i < N; i++) xin[i] = 0;
    xin[5] = -300;
    compute_ref();
    load_vec(N);
    run_xform(1'b0);
    unload_all("R2", N);
  endtask

  task automatic t_random(input int reps);
    for (int r = 0; r < reps; r++) begin
      for (int i = 0; i < N; i++) xin[i] = int'($urandom_range(4095)) - 2048;
      compute_ref();
      load_vec(N);
      run_xform(1'b0);
      unload_all("R5", N);
    end
  endtask

  task automatic t_extreme();
    for (int i = 0; i < N; i++) xin[i] = -2048;
    compute_ref();
    load_vec(N);
    run_xform(1'b0);
    unload_all("R7", N);
    for (int i = 0; i < N; i++) xin[i] = 2047;
    compute_ref();
    load_vec(N);
    run_xform(1'b0);
    unload_all("R7", N);
  endtask

  task automatic t_busy_disturb();
    for (int i = 0; i < N; i++) xin[i] = (i * 91) % 1000 - 500;
    compute_ref();
    load_vec(N);
    run_xform(1'b1);
    unload_all("R8", N);
  endtask

  task automatic t_load_wrap();
    int extra [3];
    for (int i = 0; i < N; i++) xin[i] = 100 + i;
    load_vec(N);
    extra[0] = -7; extra[1] = 1500; extra[2] = -1999;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      load_valid = 1'b1;
      load_data  = IN_W'(extra[i]);
      xin[i]     = extra[i];
    end
    @(negedge clk);
    load_valid = 1'b0;
    compute_ref();
    run_xform(1'b0);
    unload_all("R2", N);
  endtask

  task automatic t_unload_wrap();
    for (int i = 0; i < N; i++) xin[i] = (i % 3) * 200 - i;
    compute_ref();
    load_vec(N);
    run_xform(1'b0);
    unload_all("R6", N + 3);
  endtask

  initial begin
    load_valid = 1'b0;
    load_data  = '0;
    start      = 1'b0;
    unload_req = 1'b0;
    void'($urandom(32'h5eed_1234));
    t_reset();
    t_ramp();
    t_impulse();
    t_random(2);
    t_extreme();
    t_busy_disturb();
    t_load_wrap();
    t_unload_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule